// File: doc/BRIEF.md
# Branch Resolution Sequencer

This unit settles a relative branch for a small 8-bit processor core. When it accepts a request, it takes an opcode byte, four status flags (negative, overflow, zero, carry), the address of the displacement byte, the signed 8-bit displacement, and a tested memory byte. From these it decides whether the branch is taken and which address execution continues from. It also works out how many cycles the instruction costs.

There are three kinds of branch. A flag-condition branch compares one selected flag against a required value. The always-taken branch has no condition. A bit-test branch looks at one bit of the tested byte, and the opcode names that bit. Any other opcode falls through.

The result is registered on the accepting edge. The unit then stays busy for the counted number of cycles and raises a one-cycle done pulse. This lets the surrounding control logic treat it as a small timed step.

Top module: `br_resolve_unit`

## Requirements
- R1: After reset, busy, done and taken are 0, next_pc is 0 and cycles is 0.
- R2: An opcode whose low nibble is 0 and whose bit 4 is 1 is a flag branch. Opcode bits 7:6 select the flag: 00 negative, 01 overflow, 10 carry, 11 zero. The branch is taken when that flag equals opcode bit 5 (for example 0x10 is taken on negative=0 and 0xF0 on zero=1).
- R3: Opcode 0x80 is always taken, whatever the flags.
- R4: An opcode whose low nibble is 0xF is a bit branch. Bits 6:4 give the bit number of tested_byte. With opcode bit 7 = 0 the branch is taken when that bit is 0; with bit 7 = 1 it is taken when that bit is 1.
- R5: pc_in is the address of the displacement byte. A taken branch gives next_pc = pc_in + 1 + sign-extended displacement, modulo 65536. A branch that is not taken gives next_pc = pc_in + 1, also modulo 65536.
- R6: Any opcode that is not described in R2 to R4 is not taken, gives next_pc = pc_in + 1 and costs 2 cycles.
- R7: cycles is 2 when not taken and 3 when taken. It is 4 when taken and the high byte of the target differs from the high byte of pc_in + 1.
- R8: start is accepted only while busy is 0. A start raised while busy (including the done cycle) starts nothing and changes no output.
- R9: The accepting edge raises busy. done goes high exactly `cycles` clock edges after the accepting edge, lasts one cycle, and busy falls at the edge that ends done.
- R10: taken, next_pc and cycles hold their values from the accepting edge until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request; sampled while idle |
| opcode | input | 8 | Instruction opcode byte |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| tested_byte | input | 8 | Memory byte examined by bit branches |
| pc_in | input | 16 | Address of the displacement byte |
| disp | input | 8 | Signed displacement |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| taken | output | 1 | Branch taken |
| next_pc | output | 16 | Address to continue from |
| cycles | output | 3 | Cycle cost of the instruction |

## Verification
taken, next_pc and cycles are updated on the accepting edge. So they are due half a cycle after the clock edge on which start is seen while idle, and the monitor compares them at every falling edge while busy is high. done is due `cycles` edges after that accepting edge. The monitor counts falling edges from the first one where busy is seen high, and checks that count against the expected cycle cost at the done pulse. It then checks that done is low at the next falling edge. Starts raised during a run or during the done cycle have no queued item, so any run they started would be reported as unexpected.

// File: rtl/br_pkg.sv
package br_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    // Opcode encodings that the decoder depends on
    localparam logic [7:0] OP_ALWAYS     = 8'h80;
    localparam logic [3:0] LO_FLAG_BR    = 4'h0;
    localparam logic [3:0] LO_BIT_BR     = 4'hF;

    // Flag selector in opcode bits 7:6
    localparam logic [1:0] SEL_NEG   = 2'b00;
    localparam logic [1:0] SEL_OVF   = 2'b01;
    localparam logic [1:0] SEL_CARRY = 2'b10;
    localparam logic [1:0] SEL_ZERO  = 2'b11;

endpackage

// File: rtl/br_cond_decode.sv
module br_cond_decode
    import br_pkg::*;
(
    input  logic [7:0] opcode,
    input  logic       flag_n,
    input  logic       flag_v,
    input  logic       flag_z,
    input  logic       flag_c,
    input  logic [7:0] tested_byte,
    output logic       taken
);

    logic [7:0] bit_hit;
    logic       bit_val;
    logic       flag_val;

    // one lane per tested bit; only the lane named by opcode[6:4] can fire
    genvar g;
    generate
        for (g = 0; g < 8; g++) begin : g_lane
            assign bit_hit[g] = (opcode[6:4] == 3'(g)) && tested_byte[g];
        end
    endgenerate

    assign bit_val = |bit_hit;

    always_comb begin
        case (opcode[7:6])
            SEL_NEG:   flag_val = flag_n;
            SEL_OVF:   flag_val = flag_v;
            SEL_CARRY: flag_val = flag_c;
            SEL_ZERO:  flag_val = flag_z;
            default:   flag_val = 1'b0;
        endcase
    end

    always_comb begin
        taken = 1'b0;
        if (opcode == OP_ALWAYS) begin
            taken = 1'b1;
        end else if ((opcode[3:0] == LO_FLAG_BR) && opcode[4]) begin
            taken = (flag_val == opcode[5]);
        end else if (opcode[3:0] == LO_BIT_BR) begin
            taken = (bit_val == opcode[7]);
        end
    end

endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
    parameter int ADDR_W    = 16,
    parameter int DISP_W    = 8,
    parameter int PAGE_BITS = 8
) (
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] fall_pc,
    output logic [ADDR_W-1:0] tgt_pc,
    output logic              crosses
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        fall_pc  = pc_in + ADDR_W'(1);
        tgt_pc   = fall_pc + disp_ext;
        crosses  = (fall_pc[ADDR_W-1:PAGE_BITS] != tgt_pc[ADDR_W-1:PAGE_BITS]);
    end

endmodule

// File: rtl/br_cycle_seq.sv
module br_cycle_seq
    import br_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] load_cyc,
    output logic             accept,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    s_d.st  = ST_RUN;
                    s_d.cnt = load_cyc - CNT_W'(1);
                end
            end
            ST_RUN: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, cnt: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = (s_q.st != ST_IDLE);
    assign done = (s_q.st == ST_DONE);

endmodule

// File: rtl/br_resolve_unit.sv
module br_resolve_unit #(
    parameter int ADDR_W    = 16,
    parameter int DISP_W    = 8,
    parameter int PAGE_BITS = 8,
    parameter int BASE_CYC  = 2,
    parameter int TAKEN_CYC = 1,
    parameter int PAGE_CYC  = 1,
    localparam int MAX_CYC  = BASE_CYC + TAKEN_CYC + PAGE_CYC,
    localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic              flag_n,
    input  logic              flag_v,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [7:0]        tested_byte,
    input  logic [ADDR_W-1:0] pc_in,
    input  logic [DISP_W-1:0] disp,
    output logic              busy,
    output logic              done,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc,
    output logic [CNT_W-1:0]  cycles
);

    typedef struct packed {
        logic              taken;
        logic [ADDR_W-1:0] pc;
        logic [CNT_W-1:0]  cyc;
    } res_t;

    res_t r_d, r_q;

    logic              cond_taken;
    logic [ADDR_W-1:0] fall_pc;
    logic [ADDR_W-1:0] tgt_pc;
    logic              crosses;
    logic [CNT_W-1:0]  cyc_calc;
    logic              accept;

    br_cond_decode u_dec (
        .opcode      (opcode),
        .flag_n      (flag_n),
        .flag_v      (flag_v),
        .flag_z      (flag_z),
        .flag_c      (flag_c),
        .tested_byte (tested_byte),
        .taken       (cond_taken)
    );

    br_target_calc #(
        .ADDR_W    (ADDR_W),
        .DISP_W    (DISP_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_tgt (
        .pc_in   (pc_in),
        .disp    (disp),
        .fall_pc (fall_pc),
        .tgt_pc  (tgt_pc),
        .crosses (crosses)
    );

    always_comb begin
        cyc_calc = CNT_W'(BASE_CYC);
        if (cond_taken) begin
            cyc_calc = cyc_calc + CNT_W'(TAKEN_CYC);
            if (crosses) begin
                cyc_calc = cyc_calc + CNT_W'(PAGE_CYC);
            end
        end
    end

    br_cycle_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_cyc (cyc_calc),
        .accept   (accept),
        .busy     (busy),
        .done     (done)
    );

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.taken = cond_taken;
            r_d.pc    = cond_taken ? tgt_pc : fall_pc;
            r_d.cyc   = cyc_calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign taken   = r_q.taken;
    assign next_pc = r_q.pc;
    assign cycles  = r_q.cyc;

endmodule

// File: rtl/br_resolve_chk.sv
module br_resolve_chk #(
    parameter int ADDR_W   = 16,
    parameter int CNT_W    = 3,
    parameter int BASE_CYC = 2,
    parameter int MAX_CYC  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [7:0]        opcode,
    input logic              busy,
    input logic              done,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc,
    input logic [CNT_W-1:0]  cycles
);

    logic [CNT_W:0] since;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since <= '0;
        end else if (start && !busy) begin
            since <= '0;
        end else if (busy && !done) begin
            since <= since + 1'b1;
        end
    end

    // R3
    always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && opcode == 8'h80) |=> taken);

    // R7
    cyc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cycles >= CNT_W'(BASE_CYC)) && (cycles <= CNT_W'(MAX_CYC)));

    // R7
    not_taken_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !taken) |-> (cycles == CNT_W'(BASE_CYC)));

    // R8
    start_in_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !busy);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (since == {1'b0, cycles}));

    // R10
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(taken) && $stable(next_pc) && $stable(cycles)));

endmodule

bind br_resolve_unit br_resolve_chk #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .BASE_CYC (BASE_CYC),
    .MAX_CYC  (MAX_CYC)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .opcode  (opcode),
    .busy    (busy),
    .done    (done),
    .taken   (taken),
    .next_pc (next_pc),
    .cycles  (cycles)
);

// File: tb/sim_br_resolve_unit.sv
module sim_br_resolve_unit;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic        flag_n = 1'b0, flag_v = 1'b0, flag_z = 1'b0, flag_c = 1'b0;
    logic [7:0]  tested_byte = '0;
    logic [15:0] pc_in = '0;
    logic [7:0]  disp = '0;
    logic        busy, done, taken;
    logic [15:0] next_pc;
    logic [2:0]  cycles;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic        tk;
        logic [15:0] pc;
        int          cy;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    br_resolve_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .flag_n(flag_n), .flag_v(flag_v), .flag_z(flag_z), .flag_c(flag_c),
        .tested_byte(tested_byte), .pc_in(pc_in), .disp(disp),
        .busy(busy), .done(done), .taken(taken), .next_pc(next_pc), .cycles(cycles)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
        end
    endtask

    function automatic exp_t model(input logic [7:0] op, input logic [3:0] nvzc,
                                   input logic [7:0] tb, input logic [15:0] pc,
                                   input logic [7:0] d, input string tag);
        exp_t e;
        logic [15:0] fall, tgt;
        fall = pc + 16'd1;
        tgt  = fall + {{8{d[7]}}, d};
        case (op)
            8'h10: e.tk = !nvzc[3];
            8'h30: e.tk =  nvzc[3];
            8'h50: e.tk = !nvzc[2];
            8'h70: e.tk =  nvzc[2];
            8'h90: e.tk = !nvzc[0];
            8'hB0: e.tk =  nvzc[0];
            8'hD0: e.tk = !nvzc[1];
            8'hF0: e.tk =  nvzc[1];
            8'h80: e.tk = 1'b1;
            default: e.tk = (op[3:0] == 4'hF) ? (tb[op[6:4]] == op[7]) : 1'b0;
        endcase
        e.pc  = e.tk ? tgt : fall;
        e.cy  = 2 + (e.tk ? 1 : 0) + ((e.tk && fall[15:8] != tgt[15:8]) ? 1 : 0);
        e.tag = tag;
        return e;
    endfunction

    task automatic drive(input logic [7:0] op, input logic [3:0] nvzc,
                         input logic [7:0] tb, input logic [15:0] pc,
                         input logic [7:0] d);
        opcode = op;
        {flag_n, flag_v, flag_z, flag_c} = nvzc;
        tested_byte = tb;
        pc_in = pc;
        disp = d;
    endtask

    // run one request; optionally poke start while busy and during done (R8)
    task automatic run(input logic [7:0] op, input logic [3:0] nvzc,
                       input logic [7:0] tb, input logic [15:0] pc,
                       input logic [7:0] d, input string tag, input bit poke);
        q.push_back(model(op, nvzc, tb, pc, d, tag));
        @(negedge clk);
        drive(op, nvzc, tb, pc, d);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            drive(8'h80, 4'h0, 8'h00, 16'h4000, 8'h40);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        if (poke) begin
            drive(8'hF0, 4'h2, 8'h00, 16'h2222, 8'h22);
            start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compares outputs while busy, latency at done, single-cycle done
    initial begin
        bit prev_busy = 1'b0;
        bit prev_done = 1'b0;
        int elapsed = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) check(done == 1'b0, "R9", "done width", done, 0);
                if (busy) begin
                    if (!prev_busy) elapsed = 0; else elapsed++;
                    if (q.size() == 0) begin
                        check(1'b0, "R8", "unexpected run", 1, 0);
                    end else begin
                        check(taken == q[0].tk, q[0].tag, "taken", taken, q[0].tk);
                        check(next_pc == q[0].pc, q[0].tag, "next_pc", next_pc, q[0].pc);
                        check(int'(cycles) == q[0].cy, q[0].tag, "cycles R7", cycles, q[0].cy);
                        if (done) begin
                            check(elapsed == q[0].cy, "R9", "done latency", elapsed, q[0].cy);
                            void'(q.pop_front());
                        end
                    end
                end
                prev_busy = busy;
                prev_done = done;
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 0 && done == 0, "R1", "busy/done", {busy, done}, 0);
        check(taken == 0 && next_pc == 0, "R1", "taken/next_pc", {taken, next_pc}, 0);
        check(cycles == 0, "R1", "cycles", cycles, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 each flag opcode, condition true then false; flags {n,v,z,c}
        run(8'h10, 4'b0000, 8'h00, 16'h1200, 8'h05, "R2_bpl", 0);
        run(8'h10, 4'b1000, 8'h00, 16'h1200, 8'h05, "R2_bpl", 0);
        run(8'h30, 4'b1000, 8'h00, 16'h1300, 8'h06, "R2_bmi", 0);
        run(8'h30, 4'b0111, 8'h00, 16'h1300, 8'h06, "R2_bmi", 0);
        run(8'h50, 4'b1011, 8'h00, 16'h1400, 8'h07, "R2_bvc", 0);
        run(8'h50, 4'b0100, 8'h00, 16'h1400, 8'h07, "R2_bvc", 0);
        run(8'h70, 4'b0100, 8'h00, 16'h1500, 8'h08, "R2_bvs", 0);
        run(8'h70, 4'b1011, 8'h00, 16'h1500, 8'h08, "R2_bvs", 0);
        run(8'h90, 4'b1110, 8'h00, 16'h1600, 8'h09, "R2_bcc", 0);
        run(8'h90, 4'b0001, 8'h00, 16'h1600, 8'h09, "R2_bcc", 0);
        run(8'hB0, 4'b0001, 8'h00, 16'h1700, 8'h0A, "R2_bcs", 0);
        run(8'hB0, 4'b1110, 8'h00, 16'h1700, 8'h0A, "R2_bcs", 0);
        run(8'hD0, 4'b1101, 8'h00, 16'h1800, 8'h0B, "R2_bne", 0);
        run(8'hD0, 4'b0010, 8'h00, 16'h1800, 8'h0B, "R2_bne", 0);
        run(8'hF0, 4'b0010, 8'h00, 16'h1900, 8'h0C, "R2_beq", 0);
        run(8'hF0, 4'b1101, 8'h00, 16'h1900, 8'h0C, "R2_beq", 0);

        // R3 unconditional with flags clear and set
        run(8'h80, 4'b0000, 8'h00, 16'h2000, 8'h10, "R3", 0);
        run(8'h80, 4'b1111, 8'h00, 16'h2000, 8'hF0, "R3", 0);

        // R4 bit branches
        run(8'h3F, 4'b0000, 8'hF7, 16'h3000, 8'h04, "R4_rst3", 0);
        run(8'h3F, 4'b0000, 8'h08, 16'h3000, 8'h04, "R4_rst3", 0);
        run(8'hDF, 4'b0000, 8'h20, 16'h3100, 8'h04, "R4_set5", 0);
        run(8'hDF, 4'b0000, 8'hDF, 16'h3100, 8'h04, "R4_set5", 0);
        run(8'h0F, 4'b0000, 8'hFE, 16'h3200, 8'h04, "R4_rst0", 0);
        run(8'hFF, 4'b0000, 8'h80, 16'h3300, 8'h04, "R4_set7", 0);
        run(8'h7F, 4'b0000, 8'h80, 16'h3400, 8'h04, "R4_rst7", 0);

        // R5/R7 target arithmetic and page crossing
        run(8'h80, 4'b0000, 8'h00, 16'h1080, 8'h7F, "R5_max", 0);
        run(8'h80, 4'b0000, 8'h00, 16'h1080, 8'h80, "R5_min", 0);
        run(8'h80, 4'b0000, 8'h00, 16'h10FE, 8'h01, "R7_cross_fwd", 0);
        run(8'h80, 4'b0000, 8'h00, 16'h1100, 8'hFE, "R7_cross_back", 0);
        run(8'h80, 4'b0000, 8'h00, 16'hFFFF, 8'hFF, "R5_wrap", 0);
        run(8'h80, 4'b0000, 8'h00, 16'hFFFE, 8'h05, "R5_wrap_fwd", 0);
        run(8'hD0, 4'b0010, 8'h00, 16'hFFFF, 8'h40, "R5_nt_wrap", 0);

        // R6 non-branch opcodes
        run(8'hEA, 4'b1111, 8'hFF, 16'h5000, 8'h7F, "R6", 0);
        run(8'h00, 4'b0000, 8'h00, 16'h50FF, 8'h01, "R6", 0);
        run(8'h4C, 4'b1010, 8'h55, 16'h5100, 8'h80, "R6", 0);

        // R8/R10 starts while busy and during done are ignored
        run(8'h80, 4'b0000, 8'h00, 16'h60FE, 8'h02, "R8_busy", 1);
        run(8'h90, 4'b0001, 8'h00, 16'h6100, 8'h02, "R8_nt", 1);

        repeat (4) @(negedge clk);
        check(q.size() == 0, "R9", "pending results", q.size(), 0);
        check(busy == 0, "R8", "idle at end", busy, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule